// File: doc/BRIEF.md
# Narrow-Path Word Link Transmitter and Receiver

This block carries whole data words between two points over a narrow parallel path. A transmitter takes a word from a one-entry holding buffer, moves it into a shift register and sends it as a series of beats. A beat is a nibble or a byte per link clock. A receiver collects the beats and rebuilds the word. The two halves are joined inside the top module. The link pins are also brought out so the beat stream can be observed.

At run time two settings apply. `cfg_long_word` picks a 32-bit or a 48-bit word. `cfg_byte_beat` picks 4-bit or 8-bit beats. A word therefore takes 4, 6, 8 or 12 beats. Both settings may change only while the link is idle, meaning the holding buffer is empty and no beat is pending.

The word input follows valid/ready rules. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while the holding buffer is full. The source must hold `in_valid` and `in_data` stable until the word is taken. On the link, a beat is transferred on an edge where `link_strobe` and `link_ack` are both high. While `link_ack` is low the transmitter holds the beat. The receiver drives `link_ack` from the plain control input `rx_accept`. The rebuilt word leaves as a one-cycle pulse with no back-pressure.

Top module: `link_serdes`

## Requirements
- R1: After reset, `in_ready` is 1, `tx_empty` is 1, `link_strobe` is 0 and `out_valid` is 0.
- R2: With `cfg_byte_beat`=1 each beat carries 8 bits on `link_data[7:0]`. With `cfg_byte_beat`=0 each beat carries 4 bits on `link_data[3:0]`, and `link_data[7:4]` is 0.
- R3: The number of beats per word is 4 (32-bit, byte), 6 (48-bit, byte), 8 (32-bit, nibble) or 12 (48-bit, nibble).
- R4: Beats leave least-significant first. Beat k carries word bits [k*w+w-1 : k*w], where w is the beat width.
- R5: While `link_strobe` is 1 and `link_ack` is 0, on the next cycle `link_strobe` stays 1 and `link_data` is unchanged.
- R6: On the clock after the last beat of a word transfers, `out_valid` is 1 for exactly one cycle, with the rebuilt word on `out_data`. In 32-bit mode `out_data[47:32]` is 0, whatever was offered on `in_data[47:32]`.
- R7: `tx_empty` is 1 once the holding buffer has moved into the shift register. It is already 1 while the first beat of that word is on the link.
- R8: If the next word is in the holding buffer when the last beat of the current word transfers, `link_strobe` does not drop between the two words.
- R9: While the holding buffer is full, `in_ready` is 0 and offered words are not taken. The words that are taken are delivered in order, with no loss and no duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_long_word | input | 1 | 1: 48-bit words, 0: 32-bit words |
| cfg_byte_beat | input | 1 | 1: 8-bit beats, 0: 4-bit beats |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Holding buffer can take a word |
| in_data | input | 48 | Offered word |
| tx_empty | output | 1 | Holding buffer empty |
| rx_accept | input | 1 | Receiver willing to take beats |
| link_data | output | 8 | Beat on the link |
| link_strobe | output | 1 | Beat valid on the link |
| link_ack | output | 1 | Receiver acknowledge |
| out_valid | output | 1 | One-cycle rebuilt-word pulse |
| out_data | output | 48 | Rebuilt word |

## Verification
Some properties are checked by assertions on every cycle. These are: a stalled beat stays in place, the beat counters stay inside the range the mode allows, a full holding buffer keeps its word, the word-done pulse lasts one cycle, and a reload on the last beat keeps the strobe high. Other behaviour shows up only in the bench's scenarios. This covers the beat order and values in each of the four modes, and the exact cycle at which a word completes. It also covers the masking of the upper bits in 32-bit mode, `tx_empty` during the first beat, refusal of words while the buffer is full, and gapless streams with the acknowledge held high.

// File: rtl/link_pkg.sv
package link_pkg;
  localparam int LINK_WORD_W  = 48;
  localparam int LINK_SHORT_W = 32;
  localparam int LINK_BEAT_W  = 8;

  // index of the final beat for the chosen word size and beat width
  function automatic int final_beat(input logic long_word, input logic byte_beat,
                                    input int word_w, input int short_w, input int beat_w);
    int bits;
    int per;
    bits = long_word ? word_w : short_w;
    per  = byte_beat ? beat_w : beat_w / 2;
    return bits / per - 1;
  endfunction
endpackage

// File: rtl/link_tx_hold.sv
module link_tx_hold #(
  parameter int WORD_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              take,
  output logic              full,
  output logic [WORD_W-1:0] data
);
  logic accept;

  assign in_ready = !full;
  assign accept   = in_valid && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (accept) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    full && !take |=> full && $stable(data)); // R9
  AST_NO_TAKE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full); // R9
endmodule

// File: rtl/link_tx_shift.sv
module link_tx_shift
  import link_pkg::*;
#(
  parameter int WORD_W  = 48,
  parameter int SHORT_W = 32,
  parameter int BEAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_long_word,
  input  logic              cfg_byte_beat,
  input  logic              hold_full,
  input  logic [WORD_W-1:0] hold_data,
  output logic              take,
  input  logic              ack,
  output logic              strobe,
  output logic [BEAT_W-1:0] beat
);
  localparam int HALF_W = BEAT_W / 2;
  localparam int MAX_BEATS = WORD_W / HALF_W;
  localparam int CNT_W = $clog2(MAX_BEATS);
  localparam logic [WORD_W-1:0] SHORT_MASK = {{(WORD_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  logic              busy;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_idx;
  logic              fire;
  logic              at_last;

  assign last_idx = CNT_W'(final_beat(cfg_long_word, cfg_byte_beat, WORD_W, SHORT_W, BEAT_W));
  assign fire     = busy && ack;
  assign at_last  = (cnt == last_idx);
  assign take     = hold_full && (!busy || (fire && at_last));
  assign strobe   = busy;
  assign beat     = cfg_byte_beat ? shreg[BEAT_W-1:0]
                                  : {{(BEAT_W-HALF_W){1'b0}}, shreg[HALF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '0;
      cnt   <= '0;
    end else if (take) begin
      busy  <= 1'b1;
      shreg <= cfg_long_word ? hold_data : (hold_data & SHORT_MASK);
      cnt   <= '0;
    end else if (fire) begin
      if (at_last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt   <= cnt + 1'b1;
        shreg <= cfg_byte_beat ? (shreg >> BEAT_W) : (shreg >> HALF_W);
      end
    end
  end

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ack |=> busy && $stable(cnt) && $stable(shreg)); // R5
  AST_TX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= last_idx); // R3
  AST_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && at_last && hold_full |=> busy && cnt == '0); // R8
endmodule

// File: rtl/link_rx_assemble.sv
module link_rx_assemble
  import link_pkg::*;
#(
  parameter int WORD_W  = 48,
  parameter int SHORT_W = 32,
  parameter int BEAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_long_word,
  input  logic              cfg_byte_beat,
  input  logic              accept_en,
  input  logic              strobe,
  input  logic [BEAT_W-1:0] beat,
  output logic              ack,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);
  localparam int HALF_W = BEAT_W / 2;
  localparam int MAX_BEATS = WORD_W / HALF_W;
  localparam int CNT_W = $clog2(MAX_BEATS);
  localparam int SH_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_idx;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] acc_next;
  logic [WORD_W-1:0] lane;
  logic [SH_W-1:0]   shamt;
  logic              fire;

  assign ack      = accept_en;
  assign fire     = strobe && ack;
  assign last_idx = CNT_W'(final_beat(cfg_long_word, cfg_byte_beat, WORD_W, SHORT_W, BEAT_W));

  always_comb begin
    if (cfg_byte_beat) begin
      lane  = {{(WORD_W-BEAT_W){1'b0}}, beat};
      shamt = SH_W'(cnt) * SH_W'(BEAT_W);
    end else begin
      lane  = {{(WORD_W-HALF_W){1'b0}}, beat[HALF_W-1:0]};
      shamt = SH_W'(cnt) * SH_W'(HALF_W);
    end
    acc_next = acc | (lane << shamt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      acc        <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (fire) begin
        if (cnt == last_idx) begin
          word_valid <= 1'b1;
          word_data  <= acc_next;
          acc        <= '0;
          cnt        <= '0;
        end else begin
          acc <= acc_next;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R6
  AST_RX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_idx); // R3
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(cnt) && $stable(acc)); // R5
endmodule

// File: rtl/link_serdes.sv
module link_serdes
  import link_pkg::*;
#(
  parameter int WORD_W  = LINK_WORD_W,
  parameter int SHORT_W = LINK_SHORT_W,
  parameter int BEAT_W  = LINK_BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_long_word,
  input  logic              cfg_byte_beat,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              tx_empty,
  input  logic              rx_accept,
  output logic [BEAT_W-1:0] link_data,
  output logic              link_strobe,
  output logic              link_ack,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  logic              hold_full;
  logic [WORD_W-1:0] hold_data;
  logic              take;

  link_tx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .take     (take),
    .full     (hold_full),
    .data     (hold_data)
  );

  link_tx_shift #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .BEAT_W(BEAT_W)) u_tx (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_long_word (cfg_long_word),
    .cfg_byte_beat (cfg_byte_beat),
    .hold_full     (hold_full),
    .hold_data     (hold_data),
    .take          (take),
    .ack           (link_ack),
    .strobe        (link_strobe),
    .beat          (link_data)
  );

  link_rx_assemble #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .BEAT_W(BEAT_W)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_long_word (cfg_long_word),
    .cfg_byte_beat (cfg_byte_beat),
    .accept_en     (rx_accept),
    .strobe        (link_strobe),
    .beat          (link_data),
    .ack           (link_ack),
    .word_valid    (out_valid),
    .word_data     (out_data)
  );

  assign tx_empty = !hold_full;

  AST_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    take && !(in_valid && in_ready) |=> tx_empty); // R7
  AST_STROBE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    link_strobe && !link_ack |=> link_strobe && $stable(link_data)); // R5
endmodule

// File: tb/link_serdes_bench.sv
module link_serdes_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_long_word = 1'b0;
  logic        cfg_byte_beat = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_data = '0;
  logic        tx_empty;
  logic        rx_accept = 1'b0;
  logic [7:0]  link_data;
  logic        link_strobe;
  logic        link_ack;
  logic        out_valid;
  logic [47:0] out_data;

  int checks = 0;
  int fails = 0;
  int ack_pct = 100;
  bit finished = 0;
  bit mon_on = 0;

  logic [47:0] txq[$];
  logic [47:0] rxq[$];
  int  bi = 0;
  bit  pend_done = 0;
  logic [47:0] pend_word = '0;
  bit  prev_stall = 0;
  logic [7:0] prev_data = '0;
  bit  gap_mode = 0;
  int  gap_left = 0;
  bit  gap_started = 0;

  always #5 clk = ~clk;

  link_serdes u_link_serdes (
    .clk(clk), .rst_n(rst_n), .cfg_long_word(cfg_long_word), .cfg_byte_beat(cfg_byte_beat),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .tx_empty(tx_empty),
    .rx_accept(rx_accept), .link_data(link_data), .link_strobe(link_strobe),
    .link_ack(link_ack), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int n_beats(input logic lw, input logic bb);
    return (lw ? 48 : 32) / (bb ? 8 : 4);
  endfunction

  function automatic logic [47:0] masked(input logic [47:0] w, input logic lw);
    return lw ? w : {16'h0, w[31:0]};
  endfunction

  function automatic logic [7:0] beat_of(input logic [47:0] w, input int k, input logic bb);
    logic [47:0] s;
    s = w >> (k * (bb ? 8 : 4));
    return bb ? s[7:0] : {4'h0, s[3:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // random acknowledge
  always @(posedge clk) begin
    #2;
    rx_accept <= (($urandom % 100) < ack_pct);
  end

  // monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (pend_done) begin
        check(out_valid == 1'b1, "R3/R6 word-done pulse timing", {47'h0, out_valid}, 48'h1);
        check(out_data == pend_word, "R6 rebuilt word", out_data, pend_word);
        pend_done = 0;
      end else if (out_valid) begin
        check(1'b0, "R6 unexpected word-done pulse", 48'h1, 48'h0);
      end
      if (prev_stall) begin
        check(link_strobe && link_data == prev_data, "R5 beat held under stall",
              {40'h0, link_data}, {40'h0, prev_data});
      end
      if (gap_mode && gap_started && gap_left > 0)
        check(link_strobe == 1'b1, "R8 gapless strobe", {47'h0, link_strobe}, 48'h1);
      if (in_valid && in_ready) txq.push_back(masked(in_data, cfg_long_word));
      if (link_strobe && link_ack) begin
        logic [7:0] eb;
        if (txq.size() == 0) begin
          check(1'b0, "R9 beat without a word", {40'h0, link_data}, 48'h0);
        end else begin
          eb = beat_of(txq[0], bi, cfg_byte_beat);
          check(link_data == eb, bi == 0 ? "R4 first beat" : "R2/R4 beat value",
                {40'h0, link_data}, {40'h0, eb});
          bi++;
          if (gap_mode) begin gap_started = 1; gap_left--; end
          if (bi == n_beats(cfg_long_word, cfg_byte_beat)) begin
            bi = 0;
            pend_done = 1;
            pend_word = txq.pop_front();
          end
        end
      end
      prev_stall = link_strobe && !link_ack;
      prev_data  = link_data;
    end
  end

  task automatic offer(input logic [47:0] w);
    @(posedge clk); #2;
    in_valid = 1'b1;
    in_data  = w;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (!(tx_empty && !link_strobe && txq.size() == 0 && !pend_done) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic set_mode(input logic lw, input logic bb);
    wait_idle();
    @(posedge clk); #2;
    cfg_long_word = lw;
    cfg_byte_beat = bb;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #2;
    check(in_ready == 1'b1, "R1 in_ready after reset", {47'h0, in_ready}, 48'h1);
    check(tx_empty == 1'b1, "R1 tx_empty after reset", {47'h0, tx_empty}, 48'h1);
    check(link_strobe == 1'b0, "R1 strobe after reset", {47'h0, link_strobe}, 48'h0);
    check(out_valid == 1'b0, "R1 out_valid after reset", {47'h0, out_valid}, 48'h0);
    rst_n = 1'b1;
    mon_on = 1;

    // R7: first beat on the link while holding buffer already empty
    ack_pct = 100;
    offer(48'hA5A5_1234_5678);
    while (!link_strobe) @(negedge clk);
    check(tx_empty == 1'b1, "R7 empty during first beat", {47'h0, tx_empty}, 48'h1);

    // R9: buffer full refuses words
    wait_idle();
    ack_pct = 0;
    repeat (2) @(posedge clk);
    offer(48'h0000_1111_2222);
    offer(48'h0000_3333_4444);
    @(negedge clk);
    check(in_ready == 1'b0, "R9 in_ready low while full", {47'h0, in_ready}, 48'h0);
    check(tx_empty == 1'b0, "R9 tx_empty low while full", {47'h0, tx_empty}, 48'h0);
    @(posedge clk); #2;
    in_valid = 1'b1;
    in_data  = 48'hDEAD_BEEF_0000;
    repeat (5) @(posedge clk);
    #2;
    in_valid = 1'b0;
    check(txq.size() == 2, "R9 refused word not queued", txq.size(), 48'd2);
    ack_pct = 100;
    wait_idle();

    // R8: gapless streams in each mode, acknowledge held high
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0]);
      gap_left = 5 * n_beats(m[1], m[0]);
      gap_started = 0;
      gap_mode = 1;
      for (int k = 0; k < 5; k++) offer({$urandom, $urandom});
      wait_idle();
      gap_mode = 0;
    end

    // random traffic with random stalls in every mode (R2, R3, R4, R5, R6)
    for (int r = 0; r < 24; r++) begin
      set_mode($urandom % 2, $urandom % 2);
      ack_pct = 30 + ($urandom % 71);
      for (int k = 0; k < 6; k++) begin
        offer({$urandom, $urandom});
        repeat ($urandom % 3) @(posedge clk);
      end
    end
    ack_pct = 100;
    wait_idle();
    repeat (5) @(negedge clk);
    check(txq.size() == 0, "R9 every word delivered", txq.size(), 48'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule